// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block is the stall-on-issue interlock that sits beside the decode stage of a five-stage in-order pipeline. Each cycle it compares the source register indices of the instruction being decoded against the destination of the instruction now in execute. It acts only when that instruction is a valid load. A load's data leaves memory one stage too late to be forwarded into the very next instruction's execute stage, so such a dependence must be held back for one cycle.

When it finds such a dependence, the block freezes the program counter, so the same instruction is fetched again. It also freezes the fetch/decode register, so the same instruction is decoded again. Finally it tells the decode/execute register to take a no-op, so execute receives a bubble. Later stages keep moving. On the next cycle the load has left execute and the bubble holds that slot. The hazard is then gone, and ordinary forwarding from the memory/writeback path supplies the loaded value.

The block keeps no state. Detection is a purely combinational function of the decode fields and the execute-stage tags, and there is no saved copy of the stalled instruction. Stalling works by refetching and re-decoding the same instruction.

Top module: `ldu_interlock`

## Requirements
- R1: When execute holds a valid load whose destination is nonzero, the decoding instruction reads its first source (rs_used=1), and rs equals that destination, then pc_write_en=0, ifde_write_en=0 and bubble=1 in the same cycle.
- R2: When execute holds a valid load whose destination is nonzero, the decoding instruction reads its second source (rt_used=1), and rt equals that destination, then the same stall outputs as R1 are produced.
- R3: A source whose use flag is 0 never causes a stall, even if its index equals the load destination. This covers rt for immediate ALU operations and for loads.
- R4: A load destination of register index 0 never causes a stall.
- R5: When the execute stage is not valid (ex_valid=0), no stall occurs. This covers the bubble injected by a previous stall, so any stall lasts exactly one cycle.
- R6: A non-load instruction in execute (ex_is_load=0) never causes a stall, because its result can be forwarded.
- R7: With no qualifying match, pc_write_en=1, ifde_write_en=1 and bubble=0.
- R8: pc_write_en always equals ifde_write_en, and bubble is 1 exactly when both enables are 0.
- R9: The outputs depend only on the present inputs. The same input vector gives the same outputs whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | AW | First source register index of the decoding instruction |
| dec_rt | input | AW | Second source register index of the decoding instruction |
| dec_rs_used | input | 1 | Decoding instruction reads dec_rs |
| dec_rt_used | input | 1 | Decoding instruction reads dec_rt |
| ex_dst | input | AW | Destination register index of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_valid | input | 1 | Execute stage holds a real instruction (not a bubble) |
| pc_write_en | output | 1 | Program counter may advance (active high) |
| ifde_write_en | output | 1 | Fetch/decode register may load (active high) |
| bubble | output | 1 | Decode/execute register takes a no-op this cycle |

## Verification
The stimulus includes loads followed by consumers that match on rs alone, on rt alone and on both. It also includes the near misses: the matching source flagged unused, destination zero, an invalid execute slot, and a non-load producer. Each near miss separates one qualifier from the comparison itself.

A directed cycle sequence models the pipeline around one load-use pair. It checks that the stall appears in a single cycle and clears once a bubble occupies execute. Random vectors drawn from a small register range make matches frequent. They also repeat earlier vectors in new histories, which shows that the outputs carry no memory.

// File: rtl/hzl_pkg.sv
package hzl_pkg;

  // number of decode source operands checked
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_RS  = 0;
  localparam int unsigned SRC_RT  = 1;

  typedef struct packed {
    logic pc_we;
    logic ifde_we;
    logic nop_ex;
  } stall_ctl_t;

  function automatic stall_ctl_t ctl_from_hold(input logic hold);
    stall_ctl_t c;
    c.pc_we   = ~hold;
    c.ifde_we = ~hold;
    c.nop_ex  = hold;
    return c;
  endfunction

endpackage

// File: rtl/hzl_dst_qual.sv
module hzl_dst_qual #(
  parameter int unsigned AW        = 5,
  parameter bit          ZERO_HARD = 1'b1
) (
  input  logic [AW-1:0] dst,
  input  logic          is_load,
  input  logic          valid,
  output logic          dst_live
);
  localparam logic [AW-1:0] ZERO_IDX = '0;

  logic dst_nonzero;

  generate
    if (ZERO_HARD) begin : g_zero_hard
      assign dst_nonzero = (dst != ZERO_IDX);
    end else begin : g_zero_soft
      assign dst_nonzero = 1'b1;
    end
  endgenerate

  // only a valid load to a real register is an unforwardable producer
  assign dst_live = valid & is_load & dst_nonzero;
endmodule

// File: rtl/hzl_srcmatch.sv
module hzl_srcmatch #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] dst,
  input  logic          dst_live,
  output logic          hit
);
  logic idx_eq;

  assign idx_eq = (src == dst);
  assign hit    = idx_eq & src_used & dst_live;
endmodule

// File: rtl/hzl_stall_ctl.sv
module hzl_stall_ctl #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] hits,
  output logic            pc_we,
  output logic            ifde_we,
  output logic            nop_ex
);
  import hzl_pkg::*;

  logic       hold;
  stall_ctl_t ctl;

  always_comb begin
    hold = |hits;
    ctl  = ctl_from_hold(hold);
  end

  assign pc_we   = ctl.pc_we;
  assign ifde_we = ctl.ifde_we;
  assign nop_ex  = ctl.nop_ex;
endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_rs_used,
  input  logic          dec_rt_used,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_is_load,
  input  logic          ex_valid,
  output logic          pc_write_en,
  output logic          ifde_write_en,
  output logic          bubble
);
  import hzl_pkg::*;

  logic                  dst_live;
  logic [AW-1:0]         src_idx  [NUM_SRC];
  logic [NUM_SRC-1:0]    src_used;
  logic [NUM_SRC-1:0]    src_hit;

  assign src_idx[SRC_RS]  = dec_rs;
  assign src_idx[SRC_RT]  = dec_rt;
  assign src_used[SRC_RS] = dec_rs_used;
  assign src_used[SRC_RT] = dec_rt_used;

  hzl_dst_qual #(.AW(AW), .ZERO_HARD(1'b1)) u_qual (
    .dst      (ex_dst),
    .is_load  (ex_is_load),
    .valid    (ex_valid),
    .dst_live (dst_live)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      hzl_srcmatch #(.AW(AW)) u_match (
        .src      (src_idx[gi]),
        .src_used (src_used[gi]),
        .dst      (ex_dst),
        .dst_live (dst_live),
        .hit      (src_hit[gi])
      );
    end
  endgenerate

  hzl_stall_ctl #(.NSRC(NUM_SRC)) u_ctl (
    .hits    (src_hit),
    .pc_we   (pc_write_en),
    .ifde_we (ifde_write_en),
    .nop_ex  (bubble)
  );
endmodule

// File: rtl/hzl_chk.sv
module hzl_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] dec_rs,
  input logic [AW-1:0] dec_rt,
  input logic          dec_rs_used,
  input logic          dec_rt_used,
  input logic [AW-1:0] ex_dst,
  input logic          ex_is_load,
  input logic          ex_valid,
  input logic          pc_write_en,
  input logic          ifde_write_en,
  input logic          bubble
);
  logic known;

  always_comb begin
    known = !$isunknown({dec_rs, dec_rt, dec_rs_used, dec_rt_used, ex_dst,
                         ex_is_load, ex_valid, pc_write_en, ifde_write_en, bubble});
    if (known) begin
      // R1
      rs_stall_chk: assert (!(ex_valid && ex_is_load && ex_dst != '0 &&
                              dec_rs_used && dec_rs == ex_dst) || bubble)
        else $error("rs load-use did not stall");
      // R2
      rt_stall_chk: assert (!(ex_valid && ex_is_load && ex_dst != '0 &&
                              dec_rt_used && dec_rt == ex_dst) || bubble)
        else $error("rt load-use did not stall");
      // R4
      zero_dst_chk: assert (ex_dst != '0 || pc_write_en)
        else $error("stall on destination zero");
      // R5
      invalid_ex_chk: assert (ex_valid || pc_write_en)
        else $error("stall with empty execute");
      // R6
      nonload_chk: assert (ex_is_load || pc_write_en)
        else $error("stall behind non-load");
      // R8
      enable_pair_chk: assert (pc_write_en == ifde_write_en && bubble == !pc_write_en)
        else $error("enables and bubble disagree");
    end
  end
endmodule

bind ldu_interlock hzl_chk #(.AW(AW)) u_chk (
  .dec_rs        (dec_rs),
  .dec_rt        (dec_rt),
  .dec_rs_used   (dec_rs_used),
  .dec_rt_used   (dec_rt_used),
  .ex_dst        (ex_dst),
  .ex_is_load    (ex_is_load),
  .ex_valid      (ex_valid),
  .pc_write_en   (pc_write_en),
  .ifde_write_en (ifde_write_en),
  .bubble        (bubble)
);

// File: tb/sim_ldu_interlock.sv
`timescale 1ns/1ps
module sim_ldu_interlock;
  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] dec_rs, dec_rt, ex_dst;
  logic          dec_rs_used, dec_rt_used, ex_is_load, ex_valid;
  logic          pc_write_en, ifde_write_en, bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ldu_interlock #(.AW(AW)) u0 (
    .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_rs_used(dec_rs_used), .dec_rt_used(dec_rt_used),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_valid(ex_valid),
    .pc_write_en(pc_write_en), .ifde_write_en(ifde_write_en), .bubble(bubble)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_hold(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                                  input bit ur, input bit ut,
                                  input logic [AW-1:0] d, input bit ld, input bit v);
    bit live;
    live = v && ld && (d != 0);
    return live && ((ur && rs == d) || (ut && rt == d));
  endfunction

  task automatic apply(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                       input bit ur, input bit ut,
                       input logic [AW-1:0] d, input bit ld, input bit v,
                       input string tag);
    bit h;
    @(negedge clk);
    dec_rs = rs; dec_rt = rt; dec_rs_used = ur; dec_rt_used = ut;
    ex_dst = d; ex_is_load = ld; ex_valid = v;
    #2;
    h = exp_hold(rs, rt, ur, ut, d, ld, v);
    n_chk++;
    if ({pc_write_en, ifde_write_en, bubble} !== {~h, ~h, h}) begin
      n_bad++;
      $display("FAIL %s: pc/ifde/bub actual=%b%b%b expected=%b%b%b", tag,
               pc_write_en, ifde_write_en, bubble, ~h, ~h, h);
    end
  endtask

  initial begin
    int unsigned s;
    rst_n = 1'b0;
    dec_rs = '0; dec_rt = '0; dec_rs_used = 0; dec_rt_used = 0;
    ex_dst = '0; ex_is_load = 0; ex_valid = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R7 idle state after reset
    apply(0, 0, 0, 0, 0, 0, 0, "R7 idle");
    // R1
    apply(3, 9, 1, 1, 3, 1, 1, "R1 rs match");
    // R2
    apply(4, 7, 1, 1, 7, 1, 1, "R2 rt match");
    apply(7, 7, 1, 1, 7, 1, 1, "R2 both match");
    // R3
    apply(4, 7, 1, 0, 7, 1, 1, "R3 rt unused");
    apply(7, 4, 0, 1, 7, 1, 1, "R3 rs unused");
    // R4
    apply(0, 0, 1, 1, 0, 1, 1, "R4 dst zero");
    // R5
    apply(6, 2, 1, 1, 6, 1, 0, "R5 invalid ex");
    // R6
    apply(6, 6, 1, 1, 6, 0, 1, "R6 alu producer");
    // R7
    apply(1, 2, 1, 1, 31, 1, 1, "R7 no match");
    apply(31, 2, 1, 1, 31, 1, 1, "R1 top index");
    // R5 pipeline sequence: stall cycle, then bubble in execute clears it
    apply(5, 0, 1, 0, 5, 1, 1, "R5 seq stall");
    apply(5, 0, 1, 0, 5, 1, 0, "R5 seq release");
    // R9 same vector after different history
    apply(2, 8, 1, 1, 8, 1, 1, "R9 first");
    apply(0, 0, 0, 0, 0, 0, 0, "R9 between");
    apply(2, 8, 1, 1, 8, 1, 1, "R9 repeat");
    apply(2, 8, 1, 1, 9, 1, 1, "R9 near");
    // random mix over small index range (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    s = $urandom(32'd1357);
    for (int i = 0; i < 600; i++) begin
      apply($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
            $urandom % 4, ($urandom % 4) != 0, ($urandom % 4) != 0, "R8 random");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule